// File: doc/BRIEF.md
# I2C 16-bit GPIO Expander

This block is an I2C target that runs two byte-wide I/O ports. It is clocked by the system clock. SCL and SDA are oversampled through synchronizers, and SDA is driven only as a pull-low enable, so the pad outside forms the wired-AND with the master.

A write transfer carries the target address, then a command byte, then data bytes. The command byte picks one of eight byte registers: an input, output, polarity and direction register for each port. A read transfer returns bytes starting at the register the last command byte selected. A repeated START after the command byte is the usual way to read a chosen register.

The 16 pin levels are synchronized before use. Each pin has a data output and an output enable. A pin whose direction bit is 0 is driven from its output register bit.

Top module: `gpx16_target`

## Requirements
- R1: Out of reset, every output register bit is 1, every polarity bit is 0 and every direction bit is 1. So `pin_o` reads all ones, `pin_oe_o` reads all zeros and SDA is released.
- R2: The 7-bit target address is binary 0100, then a zero bit, then `sel_i[1]`, then `sel_i[0]` (0x20 + `sel_i`). An address byte holding this address is acknowledged. Any other address is not acknowledged, and the rest of that transfer up to the next START or STOP is ignored.
- R3: The target acknowledges by pulling SDA low for the whole high phase of the ninth SCL clock. The SDA pull enable changes only while the synchronized SCL is low.
- R4: The first byte after a write address is the command byte. It is always acknowledged, and its three low bits set the register pointer while the upper bits are ignored. Pointer values: 0 and 1 are the input ports, 2 and 3 the output ports, 4 and 5 the polarity registers, 6 and 7 the direction registers. An even value selects port 0, an odd value port 1.
- R5: Each data byte of a write is acknowledged and stored in the selected register. Output register bit n of port p appears on `pin_o[8*p+n]`, and `pin_o` changes only after a write.
- R6: `pin_oe_o[8*p+n]` is the inverse of direction register bit n of port p. A direction bit of 1 makes the pin an input.
- R7: Reading an input register returns the synchronized pin levels of that port, XOR-ed bit by bit with that port's polarity register. Reading any other register returns the stored value with no inversion.
- R8: Writes to the input registers are acknowledged and change nothing.
- R9: After every data byte, whether written or read, the pointer moves to the other register of its pair (0↔1, 2↔3, 4↔5, 6↔7).
- R10: In a read, the target shifts out 8 bits MSB first and then releases SDA to sample the master's acknowledge. On ACK it sends the next byte. On NACK it keeps SDA released until a STOP or START, and after that it accepts new transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sel_i | input | 2 | Low two bits of the target address |
| pin_i | input | 16 | Pin levels, port 1 in the upper byte |
| pin_o | output | 16 | Pin output data, port 1 in the upper byte |
| pin_oe_o | output | 16 | Pin output enables, 1 drives the pin |

## Verification
The bench builds the block with its default parameters: address prefix 0100 and a two-stage synchronizer. The SCL quarter period is eight system clocks, which leaves room for the synchronizer and edge-detect latency before every SDA change. Under these values, `sel_i` is changed during the run so that both a matching and a no-longer-matching address are exercised. The pointer alternation is exercised through multi-byte writes and reads, and so is the quiet period after a master NACK.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int BYTE_W = 8;
    localparam int NPORT  = 2;
    localparam int PIN_W  = NPORT * BYTE_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_HOLD
    } bus_state_e;

    typedef enum logic [1:0] {
        GRP_IN  = 2'd0,
        GRP_OUT = 2'd1,
        GRP_POL = 2'd2,
        GRP_CFG = 2'd3
    } reg_grp_e;

    // pointer layout: group in the upper two bits, port in bit 0
    typedef struct packed {
        logic [1:0] grp;
        logic       port;
    } reg_ptr_t;

    typedef struct packed {
        logic              en;
        reg_ptr_t          ptr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic reg_ptr_t ptr_pair_next(reg_ptr_t p);
        reg_ptr_t n;
        n      = p;
        n.port = ~p.port;
        return n;
    endfunction

    function automatic logic [6:0] target_addr(logic [3:0] hi, logic [1:0] sel);
        return {hi, 1'b0, sel};
    endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpx_bus_fsm.sv
module gpx_bus_fsm
    import gpx_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output wr_req_t           wr,
    output reg_ptr_t          ptr,
    output bus_state_e        state
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic              scl_q, sda_q;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] rx, tx;
    logic              rw, ack_q;
    logic              scl_rise, scl_fall, start_det, stop_det, byte_done;
    logic [6:0]        my_addr;

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    assign byte_done = (bitcnt == CNT_W'(BYTE_W));
    assign my_addr   = target_addr(ADDR_HI, sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            state    <= ST_IDLE;
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            ack_q    <= 1'b0;
            sda_pull <= 1'b0;
            ptr      <= '0;
            wr       <= '0;
        end else begin
            scl_q  <= scl_s;
            sda_q  <= sda_s;
            wr.en  <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                if (scl_rise) begin
                    if (state == ST_ADDR || state == ST_CMD || state == ST_WDAT) begin
                        rx     <= {rx[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end
                    if (state == ST_RDAT) bitcnt <= bitcnt + 1'b1;
                    if (state == ST_RACK) ack_q <= ~sda_s;
                end
                if (scl_fall) begin
                    case (state)
                        ST_ADDR: if (byte_done) begin
                            if (rx[BYTE_W-1:1] == my_addr) begin
                                sda_pull <= 1'b1;
                                rw       <= rx[0];
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state    <= ST_HOLD;
                            end
                        end
                        ST_ADDR_ACK: begin
                            bitcnt <= '0;
                            if (rw) begin
                                sda_pull <= ~rd_data[BYTE_W-1];
                                tx       <= {rd_data[BYTE_W-2:0], 1'b0};
                                state    <= ST_RDAT;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_CMD;
                            end
                        end
                        ST_CMD: if (byte_done) begin
                            ptr      <= reg_ptr_t'(rx[2:0]);
                            sda_pull <= 1'b1;
                            state    <= ST_CMD_ACK;
                        end
                        ST_CMD_ACK, ST_WDAT_ACK: begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_WDAT;
                        end
                        ST_WDAT: if (byte_done) begin
                            wr.en    <= 1'b1;
                            wr.ptr   <= ptr;
                            wr.data  <= rx;
                            ptr      <= ptr_pair_next(ptr);
                            sda_pull <= 1'b1;
                            state    <= ST_WDAT_ACK;
                        end
                        ST_RDAT: begin
                            if (byte_done) begin
                                sda_pull <= 1'b0;
                                ptr      <= ptr_pair_next(ptr);
                                state    <= ST_RACK;
                            end else begin
                                sda_pull <= ~tx[BYTE_W-1];
                                tx       <= {tx[BYTE_W-2:0], 1'b0};
                            end
                        end
                        ST_RACK: begin
                            if (ack_q) begin
                                bitcnt   <= '0;
                                sda_pull <= ~rd_data[BYTE_W-1];
                                tx       <= {rd_data[BYTE_W-2:0], 1'b0};
                                state    <= ST_RDAT;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_HOLD;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  reg_ptr_t          rd_ptr,
    input  logic [PIN_W-1:0]  pin_s,
    output logic [BYTE_W-1:0] rd_data,
    output logic [PIN_W-1:0]  out_q,
    output logic [PIN_W-1:0]  cfg_q
);
    logic [BYTE_W-1:0] out_r [NPORT];
    logic [BYTE_W-1:0] pol_r [NPORT];
    logic [BYTE_W-1:0] cfg_r [NPORT];
    logic [BYTE_W-1:0] in_v  [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic hit;
        assign hit = wr.en && (wr.ptr.port == 1'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                out_r[p] <= '1;
                pol_r[p] <= '0;
                cfg_r[p] <= '1;
            end else if (hit) begin
                case (reg_grp_e'(wr.ptr.grp))
                    GRP_OUT: out_r[p] <= wr.data;
                    GRP_POL: pol_r[p] <= wr.data;
                    GRP_CFG: cfg_r[p] <= wr.data;
                    default: ;
                endcase
            end
        end

        assign in_v[p]                   = pin_s[p*BYTE_W +: BYTE_W] ^ pol_r[p];
        assign out_q[p*BYTE_W +: BYTE_W] = out_r[p];
        assign cfg_q[p*BYTE_W +: BYTE_W] = cfg_r[p];
    end

    always_comb begin
        case (reg_grp_e'(rd_ptr.grp))
            GRP_IN:  rd_data = in_v[rd_ptr.port];
            GRP_OUT: rd_data = out_r[rd_ptr.port];
            GRP_POL: rd_data = pol_r[rd_ptr.port];
            default: rd_data = cfg_r[rd_ptr.port];
        endcase
    end
endmodule

// File: rtl/gpx16_target.sv
module gpx16_target
    import gpx_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b0100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic [1:0]       sel_i,
    input  logic [PIN_W-1:0] pin_i,
    output logic [PIN_W-1:0] pin_o,
    output logic [PIN_W-1:0] pin_oe_o
);
    logic [1:0]        bus_s;
    logic              scl_s, sda_s;
    logic [PIN_W-1:0]  pin_s, out_q, cfg_q;
    logic [BYTE_W-1:0] rd_data;
    wr_req_t           wr;
    reg_ptr_t          ptr;
    bus_state_e        fsm_state;

    gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) i_bus_sync (
        .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    gpx_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_pin_sync (
        .clk(clk), .rst(rst), .d(pin_i), .q(pin_s)
    );

    gpx_bus_fsm #(.ADDR_HI(ADDR_HI)) i_fsm (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .sel(sel_i),
        .rd_data(rd_data), .sda_pull(sda_pull_o), .wr(wr), .ptr(ptr), .state(fsm_state)
    );

    gpx_regs i_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_ptr(ptr), .pin_s(pin_s),
        .rd_data(rd_data), .out_q(out_q), .cfg_q(cfg_q)
    );

    assign pin_o    = out_q;
    assign pin_oe_o = ~cfg_q;

    // flat views for the bound checker
    logic       wr_strobe;
    logic [2:0] wr_ptr_bits, ptr_bits;
    logic       in_hold;
    assign wr_strobe   = wr.en;
    assign wr_ptr_bits = wr.ptr;
    assign ptr_bits    = ptr;
    assign in_hold     = (fsm_state == ST_HOLD);
endmodule

// File: rtl/gpx16_checker.sv
module gpx16_checker #(
    parameter int PIN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             sda_pull_o,
    input logic [PIN_W-1:0] pin_o,
    input logic [PIN_W-1:0] pin_oe_o,
    input logic             wr_strobe,
    input logic [2:0]       wr_ptr_bits,
    input logic [2:0]       ptr_bits,
    input logic             in_hold
);
    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_o == '1 && pin_oe_o == '0 && !sda_pull_o));

    assert_pull_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_s);

    assert_out_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_o) |-> $past(wr_strobe));

    assert_oe_by_write_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_oe_o) |-> $past(wr_strobe));

    assert_ptr_pair_R9: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (ptr_bits[2:1] == wr_ptr_bits[2:1] && ptr_bits[0] != wr_ptr_bits[0]));

    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        in_hold |-> !sda_pull_o);
endmodule

bind gpx16_target gpx16_checker #(.PIN_W(16)) i_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .wr_strobe(wr_strobe),
    .wr_ptr_bits(wr_ptr_bits), .ptr_bits(ptr_bits), .in_hold(in_hold)
);

// File: tb/test_gpx16_target.sv
`timescale 1ns/1ps
module test_gpx16_target;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  sel = 2'b01;
    logic [15:0] pins = '0;
    logic        sda_line, sda_pull;
    logic [15:0] pin_o, pin_oe;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    gpx16_target i_gpx16_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .sel_i(sel), .pin_i(pins),
        .pin_o(pin_o), .pin_oe_o(pin_oe)
    );

    // {command, write data, expected readback}
    localparam logic [23:0] VEC [8] = '{
        24'h02_A5_A5, 24'h03_3C_3C, 24'h04_0F_0F, 24'h05_F0_F0,
        24'h06_00_00, 24'h07_55_55, 24'h8A_5A_5A, 24'h02_5A_5A
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(1);
        s1 = sda_line; tick(2*Q-2);
        s2 = sda_line; tick(1);
        scl_m = 1'b0; tick(Q);
        ack = !s1 && !s2;
    endtask

    task automatic rbyte(output logic [7:0] b, input logic master_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(2*Q);
        end
        sda_m = master_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d, input string req);
        logic ack;
        bus_start();
        wbyte({a, 1'b0}, ack); check({req, " addr ack"}, ack, 1);
        wbyte(cmd, ack);       check({req, " cmd ack"}, ack, 1);
        wbyte(d, ack);         check({req, " data ack"}, ack, 1);
        bus_stop();
    endtask

    task automatic read_setup(input logic [6:0] a, input logic [7:0] cmd);
        logic ack;
        bus_start();
        wbyte({a, 1'b0}, ack);
        wbyte(cmd, ack);
        bus_start();
        wbyte({a, 1'b1}, ack); check("R10 read addr ack", ack, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        logic       ack;
        tick(6);
        rst = 1'b0;
        tick(6);
        // R1 reset values
        check("R1 pin_o", pin_o, 16'hFFFF);
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 sda", sda_pull, 0);

        // R4 R5 register map by table, address 0x21 (R2)
        for (int i = 0; i < 8; i++) begin
            write_reg(7'h21, VEC[i][23:16], VEC[i][15:8], "R4");
            read_setup(7'h21, VEC[i][23:16]);
            rbyte(v, 1'b0);
            bus_stop();
            check("R5 readback", v, VEC[i][7:0]);
        end
        check("R5 pin_o", pin_o, 16'h3C5A);
        check("R6 pin_oe", pin_oe, 16'hAAFF);

        // R7 input read with polarity, R9 pointer alternation on read
        pins = 16'h1234;
        tick(8);
        read_setup(7'h21, 8'h00);
        rbyte(v, 1'b1);
        rbyte(v2, 1'b0);
        bus_stop();
        check("R7 input0", v, 8'h3B);
        check("R9 input1", v2, 8'hE2);

        // R8 writes to input register are acked and ignored
        write_reg(7'h21, 8'h00, 8'h77, "R8");
        read_setup(7'h21, 8'h00);
        rbyte(v, 1'b0);
        bus_stop();
        check("R8 input unchanged", v, 8'h3B);
        check("R8 pin_o unchanged", pin_o, 16'h3C5A);
        check("R8 pin_oe unchanged", pin_oe, 16'hAAFF);

        // R9 multi-byte write alternates 6,7,6
        bus_start();
        wbyte({7'h21, 1'b0}, ack);
        wbyte(8'h06, ack);
        wbyte(8'h11, ack); check("R9 byte1 ack", ack, 1);
        wbyte(8'h22, ack); check("R9 byte2 ack", ack, 1);
        wbyte(8'h33, ack); check("R9 byte3 ack", ack, 1);
        bus_stop();
        check("R9 R6 pin_oe", pin_oe, 16'hDDCC);

        // R2 wrong address not acked, transfer ignored
        bus_start();
        wbyte({7'h23, 1'b0}, ack); check("R2 wrong addr nack", ack, 0);
        wbyte(8'h02, ack);         check("R2 ignored cmd", ack, 0);
        wbyte(8'h00, ack);         check("R2 ignored data", ack, 0);
        bus_stop();
        check("R2 pin_o unchanged", pin_o, 16'h3C5A);

        // R10 NACK then quiet until STOP, then recovery
        read_setup(7'h21, 8'h02);
        rbyte(v, 1'b0);
        check("R10 first byte", v, 8'h5A);
        rbyte(v2, 1'b0);
        check("R10 quiet after nack", v2, 8'hFF);
        bus_stop();
        read_setup(7'h21, 8'h03);
        rbyte(v, 1'b0);
        bus_stop();
        check("R10 recovered read", v, 8'h3C);

        // R2 address follows sel
        sel = 2'b10;
        tick(4);
        bus_start();
        wbyte({7'h21, 1'b0}, ack); check("R2 old addr nack", ack, 0);
        bus_stop();
        write_reg(7'h22, 8'h03, 8'h99, "R2");
        check("R5 pin_o port1", pin_o, 16'h995A);
        check("R3 released at end", sda_pull, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule